// File: doc/BRIEF.md
# Vector Sign-Bit Mask Gatherer

This execution unit takes a 32-bit instruction word, an instruction-valid strobe and a 128-bit source vector. It recognises five mask-gather operations in the instruction. For a recognised operation, it gathers the top bit of every element of the vector into a packed mask. The element width is byte, halfword, word, doubleword or quadword, and the instruction word selects it at run time. The mask is zero-extended into a 64-bit scalar result.

The result appears one clock after the instruction is accepted. A one-cycle result-valid strobe marks it. The unit also returns the destination and source register numbers taken from the instruction, so the surrounding pipeline can write the result back. An instruction that is strobed but does not match one of the five gather encodings raises a one-cycle illegal flag instead of a result. The neighbouring expand encodings share the same outer fields, and they are rejected in the same way.

Bit positions below use LSB-0 numbering of the instruction word: insn[31:26] is the major opcode, insn[25:21] the destination, insn[20:16] the variant selector, insn[15:11] the source vector register and insn[10:0] the extended opcode.

Top module: `vec_mask_extract`

## Requirements
- R1: An instruction is recognised only when insn[31:26] = 6'b000100 and insn[10:0] = 11'b11001000010. A strobed word failing either match raises illegal and produces no result.
- R2: With matching outer fields, selector insn[20:16] picks the element width: 5'b01000 byte, 5'b01001 halfword, 5'b01010 word, 5'b01011 doubleword, 5'b01100 quadword. Every other selector value is illegal.
- R3: Selector values 5'b00000 through 5'b00100 (the expand family) are never executed as gathers. They raise illegal and leave res_valid low.
- R4: For element width L = 8 << c (c = 0 for byte up to 4 for quadword), the element count is 128/L. Result bit j equals src_vec[(j+1)*L-1]. So the element at the most significant end of the vector lands in the highest used mask bit, and bit 0 holds the top bit of the lowest element.
- R5: Result bits at and above the element count are zero (bits 63:16 for byte, 63:8 for halfword, 63:4 for word, 63:2 for doubleword, 63:1 for quadword).
- R6: res_valid is high for exactly the one cycle after a clock edge at which a recognised instruction was strobed. res_data holds the mask of that instruction during that cycle.
- R7: illegal is high for exactly the one cycle after a clock edge at which an unrecognised word was strobed. res_valid and illegal are never high together.
- R8: With res_valid, res_dst carries insn[25:21] and res_src carries insn[15:11] of the accepted instruction.
- R9: While rst_n is low, res_valid and illegal are low.
- R10: A cycle with insn_valid low yields res_valid and illegal both low in the following cycle, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| insn_valid | input | 1 | Instruction word is presented this cycle |
| insn | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector operand |
| res_valid | output | 1 | Result strobe, one cycle |
| res_data | output | 64 | Zero-extended packed mask |
| res_dst | output | 5 | Destination register number |
| res_src | output | 5 | Source vector register number |
| illegal | output | 1 | Unrecognised instruction strobe, one cycle |

## Verification
On every cycle, the assertions check the mutual exclusion of the two strobes and the one-cycle relation between the input strobe and the output strobes. They also check that the expand encodings never yield a result, that upper bits are zero for the byte width, that the quadword result equals bit 127, and that the register numbers are forwarded. The exact bit ordering of each mask, the upper-zero rule at every width and the rejection of each individual bad field depend on chosen vector patterns. Only the bench scenarios show these. Its scoreboard compares every cycle's output against a model that shifts in one bit per element, starting from the most significant end.

// File: rtl/vmx_mask_pkg.sv
package vmx_mask_pkg;
  localparam int unsigned INSN_W    = 32;
  localparam int unsigned REG_W     = 5;
  localparam int unsigned NUM_SIZES = 5;
  localparam int unsigned SIZE_W    = 3;
  localparam int unsigned ELEM_MIN  = 8;

  localparam logic [5:0]  MAJOR_OP = 6'b000100;
  localparam logic [10:0] EXT_OP   = 11'b11001000010;
  localparam logic [1:0]  SEL_HI   = 2'b01;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE  = 3'd0,
    SZ_HALF  = 3'd1,
    SZ_WORD  = 3'd2,
    SZ_DWORD = 3'd3,
    SZ_QUAD  = 3'd4
  } elem_size_e;

  typedef struct packed {
    logic             legal;
    elem_size_e       size;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src;
  } dec_info_t;
endpackage

// File: rtl/vmx_decode.sv
module vmx_decode
  import vmx_mask_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_info_t         info
);
  logic [5:0]       major;
  logic [10:0]      ext;
  logic [REG_W-1:0] sel;
  logic             outer_ok;
  logic             sel_ok;

  always_comb begin
    major    = insn[31:26];
    ext      = insn[10:0];
    sel      = insn[20:16];
    outer_ok = (major == MAJOR_OP) && (ext == EXT_OP);
    sel_ok   = (sel[4:3] == SEL_HI) && (sel[2:0] < SIZE_W'(NUM_SIZES));
    info.legal = outer_ok && sel_ok;
    info.size  = elem_size_e'(sel[2:0]);
    info.dst   = insn[25:21];
    info.src   = insn[15:11];
  end
endmodule

// File: rtl/vmx_mask_gather.sv
module vmx_mask_gather
  import vmx_mask_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned RES_W = 64
)(
  input  logic [VEC_W-1:0] src_vec,
  input  elem_size_e       size,
  output logic [RES_W-1:0] mask
);
  logic [NUM_SIZES-1:0][RES_W-1:0] cand;
  logic unused_lanes;

  assign unused_lanes = ^src_vec;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int unsigned ELEM_L = ELEM_MIN << g;
    localparam int unsigned ELEM_N = VEC_W / ELEM_L;
    for (genvar j = 0; j < ELEM_N; j++) begin : g_bit
      assign cand[g][j] = src_vec[(j+1)*ELEM_L-1];
    end
    if (ELEM_N < RES_W) begin : g_pad
      assign cand[g][RES_W-1:ELEM_N] = '0;
    end
  end

  always_comb begin
    mask = '0;
    if (int'(size) < NUM_SIZES) begin
      mask = cand[size];
    end
  end
endmodule

// File: rtl/vmx_result_reg.sv
module vmx_result_reg
  import vmx_mask_pkg::*;
#(
  parameter int unsigned RES_W = 64
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_legal,
  input  logic [RES_W-1:0] in_mask,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [RES_W-1:0] out_mask,
  output logic [REG_W-1:0] out_dst,
  output logic [REG_W-1:0] out_src
);
  logic             valid_d;
  logic             illegal_d;
  logic             load_en;
  logic [RES_W-1:0] mask_q;
  logic [REG_W-1:0] dst_q;
  logic [REG_W-1:0] src_q;
  logic             valid_q;
  logic             illegal_q;

  always_comb begin
    valid_d   = in_valid && in_legal;
    illegal_d = in_valid && !in_legal;
    load_en   = valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      illegal_q <= illegal_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      mask_q <= in_mask;
      dst_q  <= in_dst;
      src_q  <= in_src;
    end
  end

  assign out_valid   = valid_q;
  assign out_illegal = illegal_q;
  assign out_mask    = mask_q;
  assign out_dst     = dst_q;
  assign out_src     = src_q;
endmodule

// File: rtl/vec_mask_extract.sv
module vec_mask_extract
  import vmx_mask_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned RES_W = 64
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               insn_valid,
  input  logic [31:0]        insn,
  input  logic [VEC_W-1:0]   src_vec,
  output logic               res_valid,
  output logic [RES_W-1:0]   res_data,
  output logic [4:0]         res_dst,
  output logic [4:0]         res_src,
  output logic               illegal
);
  dec_info_t        dec;
  logic [RES_W-1:0] mask;

  vmx_decode u_dec (
    .insn (insn),
    .info (dec)
  );

  vmx_mask_gather #(.VEC_W(VEC_W), .RES_W(RES_W)) u_gather (
    .src_vec (src_vec),
    .size    (dec.size),
    .mask    (mask)
  );

  vmx_result_reg #(.RES_W(RES_W)) u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (insn_valid),
    .in_legal    (dec.legal),
    .in_mask     (mask),
    .in_dst      (dec.dst),
    .in_src      (dec.src),
    .out_valid   (res_valid),
    .out_illegal (illegal),
    .out_mask    (res_data),
    .out_dst     (res_dst),
    .out_src     (res_src)
  );
endmodule

// File: rtl/vec_mask_extract_chk.sv
module vec_mask_extract_chk #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned RES_W = 64
)(
  input logic             clk,
  input logic             rst_n,
  input logic             insn_valid,
  input logic [31:0]      insn,
  input logic [VEC_W-1:0] src_vec,
  input logic             res_valid,
  input logic [RES_W-1:0] res_data,
  input logic [4:0]       res_dst,
  input logic [4:0]       res_src,
  input logic             illegal
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && illegal)); // R7
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(insn_valid)); // R6
  AST_ILLEGAL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(insn_valid)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> (!res_valid && !illegal)); // R10
  AST_EXPAND_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[20:16] <= 5'd4) |=> !res_valid); // R3
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(insn[20:16]) == 5'b01000) |-> res_data[RES_W-1:16] == '0); // R5
  AST_QUAD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(insn[20:16]) == 5'b01100) |-> res_data == RES_W'($past(src_vec[VEC_W-1]))); // R4
  AST_REG_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_dst == $past(insn[25:21]) && res_src == $past(insn[15:11]))); // R8
endmodule

bind vec_mask_extract vec_mask_extract_chk #(.VEC_W(VEC_W), .RES_W(RES_W)) u_chk (.*);

// File: tb/vec_mask_extract_test.sv
module vec_mask_extract_test;
  typedef struct {
    bit          kind_ok;
    bit          kind_ill;
    logic [63:0] data;
    logic [4:0]  dst;
    logic [4:0]  src;
    string       tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         insn_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] src_vec = '0;
  logic         res_valid;
  logic [63:0]  res_data;
  logic [4:0]   res_dst;
  logic [4:0]   res_src;
  logic         illegal;

  int checks = 0;
  int failures = 0;
  exp_t sb[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  vec_mask_extract uut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .src_vec(src_vec), .res_valid(res_valid), .res_data(res_data),
    .res_dst(res_dst), .res_src(res_src), .illegal(illegal)
  );

  function automatic logic [63:0] model(input int code, input logic [127:0] v);
    logic [63:0] m = '0;
    int len = 8 << code;
    int cnt = 128 / len;
    for (int k = 0; k < cnt; k++) m = (m << 1) | 64'(v[127 - k*len]);
    return m;
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] d,
                                     input logic [4:0] sel, input logic [4:0] s,
                                     input logic [10:0] xo);
    return {op, d, sel, s, xo};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [31:0] w, input logic [127:0] vec,
                       input bit legal, input int code, input string tag);
    exp_t e;
    @(negedge clk);
    #1;
    insn_valid = v;
    insn = w;
    src_vec = vec;
    e.kind_ok = v && legal;
    e.kind_ill = v && !legal;
    e.data = legal ? model(code, vec) : '0;
    e.dst = w[25:21];
    e.src = w[15:11];
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check({e.tag, " res_valid"}, 64'(res_valid), 64'(e.kind_ok));
        check({e.tag, " illegal"}, 64'(illegal), 64'(e.kind_ill));
        if (e.kind_ok) begin
          check({e.tag, " data"}, res_data, e.data);
          check("R8 dst", 64'(res_dst), 64'(e.dst));
          check("R8 src", 64'(res_src), 64'(e.src));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [5:0]  OP = 6'b000100;
  localparam logic [10:0] XO = 11'b11001000010;

  initial begin : stim
    logic [127:0] pat;
    repeat (3) @(negedge clk);
    check("R9 res_valid in reset", 64'(res_valid), 64'd0);
    check("R9 illegal in reset", 64'(illegal), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    pat = 128'h8000_7f00_80ff_0001_ff80_0080_7fff_8000;
    drive(1, mk(OP, 5'd3, 5'b01000, 5'd7, XO), pat, 1, 0, "R4 byte");
    drive(1, mk(OP, 5'd4, 5'b01001, 5'd8, XO), pat, 1, 1, "R4 half");
    drive(1, mk(OP, 5'd5, 5'b01010, 5'd9, XO), pat, 1, 2, "R4 word");
    drive(1, mk(OP, 5'd6, 5'b01011, 5'd10, XO), pat, 1, 3, "R4 dword");
    drive(1, mk(OP, 5'd7, 5'b01100, 5'd11, XO), pat, 1, 4, "R4 quad");
    drive(1, mk(OP, 5'd31, 5'b01000, 5'd1, XO), {128{1'b1}}, 1, 0, "R5 byte all ones");
    drive(1, mk(OP, 5'd1, 5'b01001, 5'd2, XO), {128{1'b1}}, 1, 1, "R5 half all ones");
    drive(1, mk(OP, 5'd2, 5'b01010, 5'd3, XO), {128{1'b1}}, 1, 2, "R5 word all ones");
    drive(1, mk(OP, 5'd0, 5'b01011, 5'd31, XO), {128{1'b1}}, 1, 3, "R5 dword all ones");
    drive(1, mk(OP, 5'd9, 5'b01100, 5'd12, XO), {128{1'b1}}, 1, 4, "R5 quad all ones");
    drive(1, mk(OP, 5'd1, 5'b01000, 5'd2, XO), {{127{1'b1}}, 1'b0} & ~(128'd1 << 127), 1, 0, "R4 byte top clear");
    drive(0, mk(OP, 5'd1, 5'b01000, 5'd2, XO), {128{1'b1}}, 1, 0, "R10 idle");
    drive(1, mk(6'b000101, 5'd1, 5'b01000, 5'd2, XO), pat, 0, 0, "R1 major opcode");
    drive(1, mk(OP, 5'd1, 5'b01000, 5'd2, 11'b11001000011), pat, 0, 0, "R1 ext opcode");
    for (int s = 0; s <= 4; s++)
      drive(1, mk(OP, 5'd2, 5'(s), 5'd3, XO), pat, 0, 0, "R3 expand selector");
    drive(1, mk(OP, 5'd2, 5'b01101, 5'd3, XO), pat, 0, 0, "R2 selector 01101");
    drive(1, mk(OP, 5'd2, 5'b11000, 5'd3, XO), pat, 0, 0, "R2 selector 11000");
    drive(1, mk(OP, 5'd2, 5'b00100, 5'd3, XO), pat, 0, 0, "R7 illegal pulse");
    drive(0, '0, '0, 0, 0, "R7 illegal drops");
    drive(1, mk(OP, 5'd12, 5'b01010, 5'd13, XO), 128'h8000_0000_0000_0000_0000_0000_8000_0000, 1, 2, "R6 result");
    drive(0, '0, '0, 0, 0, "R6 strobe drops");
    for (int n = 0; n < 8; n++) begin
      pat = {$urandom, $urandom, $urandom, $urandom};
      drive(1, mk(OP, 5'(n), 5'(8 + n % 5), 5'(n + 3), XO), pat, 1, n % 5, "R4 mixed");
    end
    drive(0, '0, '0, 0, 0, "R10 idle tail");
    repeat (3) @(negedge clk);
    check("R9 queue drained", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule